// File: doc/BRIEF.md
# Counter-Ramp Converter Controller

This block is the digital side of a counter-ramp analog-to-digital converter. A start pulse clears an up-counter whose value drives an external DAC. Each clock the counter advances by one while an external comparator reports that the analog input is still above the DAC output. When the comparator reports otherwise, counting stops and the code that first failed the comparison is kept as the digital result. A conversion therefore takes a number of clocks that grows with the input level.

The comparator output is asynchronous to the block's clock, so it passes through a synchroniser of `SYNC_STAGES` flops. The block keeps a copy of each code that travels alongside its comparator sample, and the reported result is the code that the comparator actually judged. It is not the count reached when the delayed verdict arrives. The counter stops at all ones if the comparator never trips. A new start is accepted only while idle.

Top module: `ramp_adc_ctrl`

## Requirements
- R1: Under reset, `dac_code_o`, `result_o`, `busy_o` and `done_o` are all zero.
- R2: A `start_i` sampled high while `busy_o` is low sets `busy_o` and loads `dac_code_o` with zero on that edge.
- R3: While busy, `dac_code_o` rises by exactly one per clock until it reaches all ones, and then holds there.
- R4: With the comparator high exactly for codes below a level T (T at most all ones), `result_o` equals T.
- R5: `done_o` appears SYNC_STAGES+1+T clocks after the edge that accepted start, with T clipped to all ones.
- R6: `done_o` is high for one clock only. It rises on the same edge where `busy_o` falls.
- R7: If the comparator stays high for every code, the conversion ends with `result_o` at all ones.
- R8: A `start_i` sampled while busy has no effect. This includes the clock in which the conversion is finishing: the counting, the result and the finishing time all stay as they would have been.
- R9: `result_o` changes only on the edge that raises `done_o`. It keeps its value through any later conversion until that conversion ends.
- R10: While idle, comparator activity changes none of the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin a conversion |
| cmp_above_i | input | 1 | Comparator: 1 while the analog input is above the DAC output |
| dac_code_o | output | WIDTH | Running count driving the DAC |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-clock strobe at the end of a conversion |
| result_o | output | WIDTH | Latched conversion result |

## Verification
Two events can fall in the same clock: a start request and the end of a conversion. The bench provokes this by holding `start_i` high in exactly the clock in which the delayed comparator verdict ends the conversion. It then checks three things. The finishing time and result must match the undisturbed case. `busy_o` must be low on the following clock. `dac_code_o` must not have restarted. The other case is also run: a start placed on the clock where `done_o` is visible. That start is accepted, and the bench checks that the second conversion begins from zero while the first result stays in place.

// File: rtl/ramp_adc_ctrl.sv
module ramp_adc_ctrl #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cmp_above_i,
  output logic [WIDTH-1:0] dac_code_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] result_o
);
  localparam int LAST = SYNC_STAGES - 1;
  localparam logic [WIDTH-1:0] FULL = '1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] vld_q;
  logic [WIDTH-1:0]       code_q [SYNC_STAGES];
  logic                   start_ok;
  logic                   finish;

  assign start_ok = start_i && !busy_o;
  assign finish   = busy_o && vld_q[LAST] && (!sync_q[LAST] || code_q[LAST] == FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], cmp_above_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < SYNC_STAGES; i++) code_q[i] <= '0;
    end else if (start_ok) begin
      vld_q <= '0;
    end else if (busy_o) begin
      vld_q     <= {vld_q[SYNC_STAGES-2:0], 1'b1};
      code_q[0] <= dac_code_o;
      for (int i = 1; i < SYNC_STAGES; i++) code_q[i] <= code_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_code_o <= '0;
      busy_o     <= 1'b0;
      done_o     <= 1'b0;
      result_o   <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_ok) begin
        busy_o     <= 1'b1;
        dac_code_o <= '0;
      end else if (finish) begin
        busy_o   <= 1'b0;
        done_o   <= 1'b1;
        result_o <= code_q[LAST];
      end else if (busy_o && dac_code_o != FULL) begin
        dac_code_o <= dac_code_o + 1'b1;
      end
    end
  end

  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && dac_code_o == '0));

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && $past(dac_code_o) != FULL) |-> dac_code_o == $past(dac_code_o) + 1'b1);

  assert_full_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && $past(dac_code_o) == FULL) |-> dac_code_o == FULL);

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_ends_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> (!busy_o && $past(busy_o)));

  assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(result_o));

  assert_idle_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> $stable(dac_code_o));
endmodule

// File: tb/ramp_adc_ctrl_tb.sv
module ramp_adc_ctrl_tb_top;
  localparam int W = 8;
  localparam int SY = 2;
  localparam int MAXC = (1 << W) - 1;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic cmp;
  logic [W-1:0] dac_code, result;
  logic busy, done;
  int thr = 0;
  logic force_en = 1'b0;
  logic force_val = 1'b0;
  int checks = 0;
  int failures = 0;
  int last_result = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign cmp = force_en ? force_val : (thr > int'(dac_code));

  ramp_adc_ctrl #(.WIDTH(W), .SYNC_STAGES(SY)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cmp_above_i(cmp),
    .dac_code_o(dac_code), .busy_o(busy), .done_o(done), .result_o(result));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clip(input int v);
    return (v > MAXC) ? MAXC : v;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic t_reset();
    @(negedge clk);
    chk(dac_code == 0 && result == 0 && !busy && !done, "R1 reset state",
        {busy, done, dac_code}, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Wait for done after an accepted start; n counts edges since acceptance.
  task automatic wait_done(input int t, input int pulse_at, input int pulse_len,
                           input string tag, output int n_out);
    int n = 0;
    bit step_ok = 1;
    bit hold_ok = 1;
    int bad_code = 0;
    int exp_res = clip(t);
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
      if (done) break;
      if (busy && int'(dac_code) != clip(n)) begin step_ok = 0; bad_code = dac_code; end
      if (int'(result) != last_result) hold_ok = 0;
      start = (pulse_at >= 0 && n >= pulse_at && n < pulse_at + pulse_len);
    end
    start = 1'b0;
    chk(step_ok, {tag, " R3 code steps"}, bad_code, -1);
    chk(hold_ok, {tag, " R9 result held during conversion"}, result, last_result);
    chk(n == SY + 1 + exp_res, {tag, " R5 done timing"}, n, SY + 1 + exp_res);
    chk(int'(result) == exp_res, {tag, (t > MAXC) ? " R7 full scale result" : " R4 result"},
        result, exp_res);
    chk(!busy, {tag, " R6 busy low with done"}, busy, 0);
    last_result = result;
    n_out = n;
  endtask

  task automatic run_conv(input int t, input int pulse_at, input int pulse_len, input string tag);
    int n;
    logic [W-1:0] code_at_done;
    thr = t;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && dac_code == 0, {tag, " R2 start accepted"}, dac_code, 0);
    wait_done(t, pulse_at, pulse_len, tag, n);
    code_at_done = dac_code;
    @(negedge clk);
    chk(!done, {tag, " R6 done one cycle"}, done, 0);
    chk(!busy && dac_code == code_at_done, {tag, " R8 no restart after stop"},
        dac_code, code_at_done);
  endtask

  task automatic t_back_to_back(input int t1, input int t2);
    int n;
    thr = t1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(t1, -1, 0, "b2b-first", n);
    thr = t2;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && dac_code == 0 && !done, "R2 start on done cycle accepted", dac_code, 0);
    chk(int'(result) == clip(t1), "R9 first result kept at restart", result, clip(t1));
    wait_done(t2, -1, 0, "b2b-second", n);
    @(negedge clk);
  endtask

  task automatic t_idle_cmp();
    logic [W-1:0] c0 = dac_code;
    logic [W-1:0] r0 = result;
    bit ok = 1;
    force_en = 1'b1;
    for (int i = 0; i < 12; i++) begin
      force_val = i[0] ^ i[2];
      @(negedge clk);
      if (busy || done || dac_code != c0 || result != r0) ok = 0;
    end
    force_en = 1'b0;
    chk(ok, "R10 idle comparator activity ignored", dac_code, c0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    run_conv(0, -1, 0, "zero");
    run_conv(1, -1, 0, "one");
    run_conv(37, -1, 0, "mid");
    run_conv(MAXC, -1, 0, "top");
    run_conv(MAXC + 40, -1, 0, "over");
    run_conv(50, 10, 3, "restart-mid");
    run_conv(20, 20 + SY, 1, "start-at-stop");
    t_idle_cmp();
    t_back_to_back(9, 120);
    t_idle_cmp();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule